// File: doc/BRIEF.md
# Host Command Decoder with Register Bank

This block sits behind a host link and receives command packets as a stream of bytes with a valid/ready handshake and a last-byte marker. The first byte of each packet selects an operation. Each operation then consumes a header of its own shape, and sometimes a payload. Register writes go into a bank of 32-bit registers. Every register value is presented on a flat output bus for the logic that uses it. Register reads return the addressed word as four bytes on a second valid/ready stream, most significant byte first.

Two register indices have a special role. Index 2 reads back as a fixed status pattern, and its least significant bit reports whether the key pair in indices 16 and 17 holds the expected code. A value written to index 2 still reaches the register output, but reads of index 2 never return it. Firmware chunk bytes leave the block as single-cycle byte strobes. A one-cycle pulse marks the start of a firmware upload, and a data-read request produces a single strobe carrying its argument byte. Memory-read requests are parsed and consumed with no effect, because the memory lies outside the block. The last-byte marker lets the parser recover from unknown, truncated or overlong packets.

Top module: `hostcmd_regbank`

## Requirements
- R1: While reset is held and just after it is released, every register is zero, all strobes are low, out_valid is 0 and in_ready is 1.
- R2: A write packet is code 4, an address byte, a length byte N and N data bytes. The register index is address[7:2], and address bits [1:0] are ignored. The register takes the last up to four data bytes as a big-endian value, zero-extended, at the edge that accepts the final data byte. If N is 0, or if in_last arrives before N data bytes, nothing is written.
- R3: A write to an index of NREG or above changes no register, and a read of such an index returns 0.
- R4: A read packet is code 3, an address byte and a length byte, which is ignored. The reply is the addressed 32-bit word sent as four bytes on out_data, most significant first. out_data and out_valid hold steady while out_ready is low.
- R5: in_ready is low from the edge that accepts a read's length byte until the fourth reply byte is taken, so no command overlaps a reply.
- R6: A read of index 2 returns 0xA5A5A5A0 with bit 0 set exactly when index 16 holds 0x641381F6 and index 17 holds 0x00000000. A value written to index 2 appears on the register output but not in reads.
- R7: A chunk packet is code 2, a length byte L and L payload bytes. Each payload byte appears on fw_byte with a one-cycle fw_valid pulse, in arrival order. If L exceeds 250, the payload is consumed with no pulses.
- R8: Code 1 produces a one-cycle fw_init pulse.
- R9: Code 7 followed by one byte produces a single one-cycle drd_stb pulse with that byte on drd_arg.
- R10: A memory-read packet is code 5, an address high byte, an address low byte and a length byte. It is consumed with no output or register effect.
- R11: A packet with any other code, and any bytes past a packet's expected end, are dropped up to and including the byte marked in_last. The next byte is then taken as a command code.
- R12: Register outputs, strobes, in_ready and the reply stream change only at the clock edge that accepts the deciding byte or reply byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Decoder accepts a byte |
| out_valid | output | 1 | Reply byte valid |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Consumer takes a reply byte |
| regs_flat | output | NREG*32 | All register values, index i at bits [32*i+31:32*i] |
| fw_init | output | 1 | Firmware upload start pulse |
| fw_valid | output | 1 | Firmware payload byte strobe |
| fw_byte | output | 8 | Firmware payload byte |
| drd_stb | output | 1 | Data-read request strobe |
| drd_arg | output | 8 | Data-read argument byte |

## Verification
The hardest cases to reach from the ports are recovery from a damaged packet and the timing of a reply under backpressure. These include a write cut short by an early last marker, a read that carries a trailing byte which must be drained after the reply, and an unknown packet whose payload contains valid command codes. The bench sends each of these shapes on purpose while out_ready follows an irregular pattern, so reply bytes stall at varying points. A behavioural model with queues predicts in_ready, the reply bytes and every strobe on each clock. The status bit is checked through a sequence of key writes: the wrong second key, then the right first key, then the right second key.

// File: rtl/hostcmd_pkg.sv
package hostcmd_pkg;
  localparam int IDX_W = 6;
  localparam logic [31:0] STATUS_BASE = 32'hA5A5A5A0;

  localparam logic [7:0] OP_FW_INIT  = 8'd1;
  localparam logic [7:0] OP_FW_CHUNK = 8'd2;
  localparam logic [7:0] OP_REG_RD   = 8'd3;
  localparam logic [7:0] OP_REG_WR   = 8'd4;
  localparam logic [7:0] OP_MEM_RD   = 8'd5;
  localparam logic [7:0] OP_DATA_RD  = 8'd7;

  typedef enum logic [2:0] {
    PS_IDLE, PS_ADDR, PS_LEN, PS_DATA, PS_SKIP, PS_ARG, PS_REPLY, PS_DRAIN
  } pstate_e;
endpackage

// File: rtl/hostcmd_parser.sv
module hostcmd_parser
  import hostcmd_pkg::*;
#(
  parameter int MAX_CHUNK = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [31:0]      wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rsp_load,
  input  logic             rsp_done,
  output logic             fw_init,
  output logic             fw_valid,
  output logic [7:0]       fw_byte,
  output logic             drd_stb,
  output logic [7:0]       drd_arg
);
  pstate_e     st_q, st_n;
  logic [7:0]  cmd_q, cmd_n, addr_q, addr_n, cnt_q, cnt_n;
  logic [31:0] acc_q, acc_n;
  logic        ok_q, ok_n, drain_q, drain_n;
  logic        init_n, fwv_n, drd_n;
  logic [7:0]  fwb_n, darg_n;
  logic        take;

  assign in_ready = (st_q != PS_REPLY);
  assign take     = in_valid && in_ready;
  assign wr_idx   = addr_q[7:2];
  assign rd_idx   = addr_q[7:2];
  assign wr_data  = {acc_q[23:0], in_data};

  always_comb begin
    st_n = st_q; cmd_n = cmd_q; addr_n = addr_q; cnt_n = cnt_q;
    acc_n = acc_q; ok_n = ok_q; drain_n = drain_q;
    init_n = 1'b0; fwv_n = 1'b0; drd_n = 1'b0;
    fwb_n = fw_byte; darg_n = drd_arg;
    wr_en = 1'b0; rsp_load = 1'b0;
    case (st_q)
      PS_IDLE: if (take) begin
        cmd_n = in_data;
        case (in_data)
          OP_FW_INIT:  begin init_n = 1'b1; st_n = PS_DRAIN; end
          OP_FW_CHUNK: st_n = PS_LEN;
          OP_REG_RD,
          OP_REG_WR:   st_n = PS_ADDR;
          OP_MEM_RD:   begin cnt_n = 8'd3; st_n = PS_SKIP; end
          OP_DATA_RD:  st_n = PS_ARG;
          default:     st_n = PS_DRAIN;
        endcase
        if (in_last) st_n = PS_IDLE;
      end
      PS_ADDR: if (take) begin
        addr_n = in_data;
        st_n   = in_last ? PS_IDLE : PS_LEN;
      end
      PS_LEN: if (take) begin
        if (cmd_q == OP_REG_RD) begin
          rsp_load = 1'b1;
          drain_n  = !in_last;
          st_n     = PS_REPLY;
        end else begin
          cnt_n = in_data;
          acc_n = '0;
          ok_n  = (int'(in_data) <= MAX_CHUNK);
          if (in_last)            st_n = PS_IDLE;
          else if (in_data == 0)  st_n = PS_DRAIN;
          else                    st_n = PS_DATA;
        end
      end
      PS_DATA: if (take) begin
        cnt_n = cnt_q - 8'd1;
        if (cmd_q == OP_REG_WR) acc_n = wr_data;
        else if (ok_q) begin fwv_n = 1'b1; fwb_n = in_data; end
        if (cnt_q == 8'd1) begin
          wr_en = (cmd_q == OP_REG_WR);
          st_n  = in_last ? PS_IDLE : PS_DRAIN;
        end else if (in_last) st_n = PS_IDLE;
      end
      PS_SKIP: if (take) begin
        cnt_n = cnt_q - 8'd1;
        if (cnt_q == 8'd1) st_n = in_last ? PS_IDLE : PS_DRAIN;
        else if (in_last)  st_n = PS_IDLE;
      end
      PS_ARG: if (take) begin
        drd_n  = 1'b1;
        darg_n = in_data;
        st_n   = in_last ? PS_IDLE : PS_DRAIN;
      end
      PS_REPLY: if (rsp_done) st_n = drain_q ? PS_DRAIN : PS_IDLE;
      PS_DRAIN: if (take && in_last) st_n = PS_IDLE;
      default: st_n = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_IDLE; cmd_q <= '0; addr_q <= '0; cnt_q <= '0;
      acc_q <= '0; ok_q <= 1'b0; drain_q <= 1'b0;
      fw_init <= 1'b0; fw_valid <= 1'b0; fw_byte <= '0;
      drd_stb <= 1'b0; drd_arg <= '0;
    end else begin
      st_q <= st_n; cmd_q <= cmd_n; addr_q <= addr_n; cnt_q <= cnt_n;
      acc_q <= acc_n; ok_q <= ok_n; drain_q <= drain_n;
      fw_init <= init_n; fw_valid <= fwv_n; fw_byte <= fwb_n;
      drd_stb <= drd_n; drd_arg <= darg_n;
    end
  end

  a_r9_single_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    drd_stb |=> !drd_stb);
  a_r8_init_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fw_init |=> !fw_init);
endmodule

// File: rtl/hostcmd_bank.sv
module hostcmd_bank
  import hostcmd_pkg::*;
#(
  parameter int          NREG       = 18,
  parameter int          STATUS_IDX = 2,
  parameter int          KEY0_IDX   = 16,
  parameter int          KEY1_IDX   = 17,
  parameter logic [31:0] KEY0_VAL   = 32'h641381F6,
  parameter logic [31:0] KEY1_VAL   = 32'h00000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_word,
  output logic [NREG*32-1:0] regs_flat
);
  localparam int LW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [31:0] word_w [NREG];
  logic        unlocked;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [31:0] q;
    logic        hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign word_w[g] = q;
    assign regs_flat[g*32 +: 32] = q;
  end

  assign unlocked = (word_w[KEY0_IDX] == KEY0_VAL) && (word_w[KEY1_IDX] == KEY1_VAL);

  always_comb begin
    if (rd_idx == IDX_W'(STATUS_IDX))  rd_word = STATUS_BASE | {31'd0, unlocked};
    else if (rd_idx < IDX_W'(NREG))    rd_word = word_w[rd_idx[LW-1:0]];
    else                               rd_word = '0;
  end

  a_r6_unlock_needs_key_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en) &&
      (($past(wr_idx) == IDX_W'(KEY0_IDX)) || ($past(wr_idx) == IDX_W'(KEY1_IDX))));
  a_r3_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDX_W'(NREG))) |=> $stable(regs_flat));
endmodule

// File: rtl/hostcmd_reply.sv
module hostcmd_reply #(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [8*BYTES-1:0] word,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             done
);
  localparam int CW = $clog2(BYTES + 1);

  logic [8*BYTES-1:0] buf_q, buf_n;
  logic [CW-1:0]      cnt_q, cnt_n;

  assign out_valid = (cnt_q != '0);
  assign out_data  = buf_q[8*BYTES-1 -: 8];
  assign done      = out_valid && out_ready && (cnt_q == CW'(1));

  always_comb begin
    buf_n = buf_q;
    cnt_n = cnt_q;
    if (!out_valid && load) begin
      buf_n = word;
      cnt_n = CW'(BYTES);
    end else if (out_valid && out_ready) begin
      buf_n = buf_q << 8;
      cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      buf_q <= buf_n;
      cnt_q <= cnt_n;
    end
  end

  a_r4_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/hostcmd_regbank.sv
module hostcmd_regbank
  import hostcmd_pkg::*;
#(
  parameter int NREG      = 18,
  parameter int MAX_CHUNK = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic               in_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  input  logic               out_ready,
  output logic [NREG*32-1:0] regs_flat,
  output logic               fw_init,
  output logic               fw_valid,
  output logic [7:0]         fw_byte,
  output logic               drd_stb,
  output logic [7:0]         drd_arg
);
  logic             wr_en, rsp_load, rsp_done;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [31:0]      wr_data, rd_word;

  hostcmd_parser #(.MAX_CHUNK(MAX_CHUNK)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rsp_load(rsp_load), .rsp_done(rsp_done),
    .fw_init(fw_init), .fw_valid(fw_valid), .fw_byte(fw_byte),
    .drd_stb(drd_stb), .drd_arg(drd_arg)
  );

  hostcmd_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_word(rd_word), .regs_flat(regs_flat)
  );

  hostcmd_reply #(.BYTES(4)) u_reply (
    .clk(clk), .rst_n(rst_n),
    .load(rsp_load), .word(rd_word),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(rsp_done)
  );

  a_r5_ready_low_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

// File: tb/hostcmd_regbank_bench.sv
module hostcmd_regbank_bench;
  localparam int NREG = 18;
  localparam int W = NREG * 32;

  logic clk, rst_n;
  logic in_valid, in_last, in_ready, out_valid, out_ready;
  logic [7:0] in_data, out_data, fw_byte, drd_arg;
  logic [W-1:0] regs_flat;
  logic fw_init, fw_valid, drd_stb;

  hostcmd_regbank #(.NREG(NREG), .MAX_CHUNK(250)) u_hostcmd_regbank (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .regs_flat(regs_flat),
    .fw_init(fw_init), .fw_valid(fw_valid), .fw_byte(fw_byte),
    .drd_stb(drd_stb), .drd_arg(drd_arg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit run_cmp = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mreg [NREG];
  logic [7:0]  rq[$];
  logic [7:0]  rxq[$];
  logic [7:0]  fwq[$];
  int mst, mcnt;
  logic [7:0] mcmd, maddr, e_fwb, e_darg, last_arg;
  logic [31:0] macc;
  bit mok, e_init, e_fwv, e_drd, mrdy;
  int n_init = 0, n_drd = 0, n_overlap = 0;

  function automatic logic [31:0] mread(input int idx);
    if (idx == 2)
      return 32'hA5A5A5A0 | {31'd0, (mreg[16] == 32'h641381F6) && (mreg[17] == 32'h0)};
    else if (idx < NREG) return mreg[idx];
    else return 32'h0;
  endfunction

  function automatic logic [W-1:0] mflat();
    logic [W-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*32 +: 32] = mreg[i];
    return f;
  endfunction

  task automatic mproc(input logic [7:0] b, input bit last);
    logic [31:0] w;
    case (mst)
      0: begin
        mcmd = b;
        case (b)
          8'd1: begin e_init = 1; mst = 6; end
          8'd2: mst = 2;
          8'd3, 8'd4: mst = 1;
          8'd5: begin mcnt = 3; mst = 4; end
          8'd7: mst = 5;
          default: mst = 6;
        endcase
        if (last) mst = 0;
      end
      1: begin maddr = b; mst = last ? 0 : 2; end
      2: if (mcmd == 8'd3) begin
           w = mread(int'(maddr[7:2]));
           rq.push_back(w[31:24]); rq.push_back(w[23:16]);
           rq.push_back(w[15:8]);  rq.push_back(w[7:0]);
           mst = last ? 0 : 6;
         end else begin
           mcnt = int'(b); macc = 0; mok = (b <= 8'd250);
           mst = last ? 0 : ((b == 0) ? 6 : 3);
         end
      3: begin
        if (mcmd == 8'd4) macc = {macc[23:0], b};
        else if (mok) begin e_fwv = 1; e_fwb = b; end
        if (mcnt == 1) begin
          if (mcmd == 8'd4 && int'(maddr[7:2]) < NREG) mreg[maddr[7:2]] = macc;
          mst = last ? 0 : 6;
        end else if (last) mst = 0;
        mcnt--;
      end
      4: begin
        if (mcnt == 1) mst = last ? 0 : 6;
        else if (last) mst = 0;
        mcnt--;
      end
      5: begin e_drd = 1; e_darg = b; mst = last ? 0 : 6; end
      default: if (last) mst = 0;
    endcase
  endtask

  always @(posedge clk) begin
    e_init = 0; e_fwv = 0; e_drd = 0;
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mreg[i] = 0;
      rq.delete(); mst = 0; mcnt = 0; e_fwb = 0; e_darg = 0;
    end else begin
      mrdy = (rq.size() == 0);
      if (out_valid && out_ready) rxq.push_back(out_data);
      if (rq.size() > 0 && out_ready) void'(rq.pop_front());
      if (in_valid && mrdy) mproc(in_data, in_last);
    end
  end

  // per-cycle comparison, R12 timing
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(regs_flat == mflat(), "R12 registers", regs_flat, mflat());
      chk(in_ready == (rq.size() == 0), "R12 in_ready", W'(in_ready), W'(rq.size() == 0));
      chk(out_valid == (rq.size() != 0), "R12 out_valid", W'(out_valid), W'(rq.size() != 0));
      if (rq.size() != 0) chk(out_data == rq[0], "R12 out_data", W'(out_data), W'(rq[0]));
      chk(fw_valid == e_fwv, "R12 fw_valid", W'(fw_valid), W'(e_fwv));
      if (e_fwv) chk(fw_byte == e_fwb, "R12 fw_byte", W'(fw_byte), W'(e_fwb));
      chk(fw_init == e_init, "R12 fw_init", W'(fw_init), W'(e_init));
      chk(drd_stb == e_drd, "R12 drd_stb", W'(drd_stb), W'(e_drd));
      if (e_drd) chk(drd_arg == e_darg, "R12 drd_arg", W'(drd_arg), W'(e_darg));
    end
    if (rst_n) begin
      if (fw_valid) fwq.push_back(fw_byte);
      if (fw_init) n_init++;
      if (drd_stb) begin n_drd++; last_arg = drd_arg; end
      if (out_valid && in_ready) n_overlap++;
    end
  end

  // irregular consumer backpressure
  initial begin
    int cyc = 0;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 4) != 2) && ((cyc % 7) != 3);
    end
  end

  task automatic pkt(input logic [7:0] q[$]);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = q[i]; in_last = (i == q.size() - 1);
      forever begin
        if (in_ready) begin @(posedge clk); break; end
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] addr, output logic [31:0] w);
    rxq.delete();
    pkt('{8'd3, addr, 8'd4});
    while (rxq.size() < 4) @(negedge clk);
    w = {rxq[0], rxq[1], rxq[2], rxq[3]};
  endtask

  function automatic logic [31:0] rword(input int idx);
    return regs_flat[idx*32 +: 32];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [W-1:0] snap;
    int k;
    logic [7:0] q[$];
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(regs_flat == '0, "R1 regs in reset", regs_flat, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(regs_flat == '0 && in_ready && !out_valid && !fw_valid && !fw_init && !drd_stb,
        "R1 after reset", W'({in_ready, out_valid, fw_valid, fw_init, drd_stb}), W'(5'b10000));
    run_cmp = 1;

    pkt('{8'd4, 8'h14, 8'd4, 8'h11, 8'h22, 8'h33, 8'h44});
    chk(rword(5) == 32'h11223344, "R2 full write", W'(rword(5)), W'(32'h11223344));
    pkt('{8'd4, 8'h1B, 8'd2, 8'hAB, 8'hCD});
    chk(rword(6) == 32'h0000ABCD, "R2 short write", W'(rword(6)), W'(32'h0000ABCD));
    pkt('{8'd4, 8'h1C, 8'd6, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06});
    chk(rword(7) == 32'h03040506, "R2 long write", W'(rword(7)), W'(32'h03040506));
    pkt('{8'd4, 8'h14, 8'd0});
    pkt('{8'd4, 8'h14, 8'd4, 8'h99, 8'h88});
    chk(rword(5) == 32'h11223344, "R2 empty or truncated write", W'(rword(5)), W'(32'h11223344));

    snap = regs_flat;
    pkt('{8'd4, 8'h50, 8'd4, 8'hDE, 8'hAD, 8'hBE, 8'hEF});
    chk(regs_flat == snap, "R3 out of range write", regs_flat, snap);
    rd(8'h50, w);
    chk(w == 32'h0, "R3 out of range read", W'(w), '0);

    rd(8'h14, w);
    chk(w == 32'h11223344, "R4 read reg5", W'(w), W'(32'h11223344));
    rd(8'h1B, w);
    chk(w == 32'h0000ABCD, "R4 read reg6", W'(w), W'(32'h0000ABCD));

    rd(8'h08, w);
    chk(w == 32'hA5A5A5A0, "R6 locked status", W'(w), W'(32'hA5A5A5A0));
    pkt('{8'd4, 8'h44, 8'd4, 8'h00, 8'h00, 8'h00, 8'h01});
    pkt('{8'd4, 8'h40, 8'd4, 8'h64, 8'h13, 8'h81, 8'hF6});
    rd(8'h08, w);
    chk(w == 32'hA5A5A5A0, "R6 wrong second key", W'(w), W'(32'hA5A5A5A0));
    pkt('{8'd4, 8'h44, 8'd4, 8'h00, 8'h00, 8'h00, 8'h00});
    rd(8'h08, w);
    chk(w == 32'hA5A5A5A1, "R6 unlocked status", W'(w), W'(32'hA5A5A5A1));
    pkt('{8'd4, 8'h08, 8'd4, 8'h12, 8'h34, 8'h56, 8'h78});
    chk(rword(2) == 32'h12345678, "R6 index2 register output", W'(rword(2)), W'(32'h12345678));
    rd(8'h08, w);
    chk(w == 32'hA5A5A5A1, "R6 index2 read stays status", W'(w), W'(32'hA5A5A5A1));

    k = n_init;
    rxq.delete();
    pkt('{8'd3, 8'h14, 8'd4, 8'd1});
    while (rxq.size() < 4) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_init == k, "R11 trailing byte after read drained", W'(n_init), W'(k));
    chk(n_overlap == 0, "R5 no input accepted during reply", W'(n_overlap), '0);

    fwq.delete();
    pkt('{8'd2, 8'd5, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4});
    chk(fwq.size() == 5 && fwq[0] == 8'hA0 && fwq[4] == 8'hA4, "R7 small chunk",
        W'(fwq.size()), W'(5));
    fwq.delete();
    q.delete(); q.push_back(8'd2); q.push_back(8'd250);
    for (int i = 0; i < 250; i++) q.push_back(8'(i));
    pkt(q);
    chk(fwq.size() == 250 && fwq[249] == 8'd249, "R7 chunk of 250", W'(fwq.size()), W'(250));
    fwq.delete();
    q.delete(); q.push_back(8'd2); q.push_back(8'd251);
    for (int i = 0; i < 251; i++) q.push_back(8'(i));
    pkt(q);
    chk(fwq.size() == 0, "R7 oversize chunk silent", W'(fwq.size()), '0);

    k = n_init;
    pkt('{8'd1});
    chk(n_init == k + 1, "R8 upload start pulse", W'(n_init), W'(k + 1));

    k = n_drd;
    pkt('{8'd7, 8'h3C});
    chk(n_drd == k + 1 && last_arg == 8'h3C, "R9 data read strobe", W'(last_arg), W'(8'h3C));

    snap = regs_flat;
    k = n_init + n_drd + fwq.size();
    pkt('{8'd5, 8'h0F, 8'hA0, 8'd8});
    chk(regs_flat == snap && (n_init + n_drd + fwq.size()) == k, "R10 memory read consumed",
        W'(n_init + n_drd + fwq.size()), W'(k));

    k = n_init + n_drd;
    pkt('{8'd9, 8'd1, 8'd7, 8'h55});
    chk((n_init + n_drd) == k, "R11 unknown packet dropped", W'(n_init + n_drd), W'(k));
    pkt('{8'd1});
    chk(n_init == k - n_drd + 1, "R11 resync after unknown", W'(n_init), W'(k - n_drd + 1));

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule